// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block watches the stream of 16-bit audio words recovered from consecutive sub-frames of a digital audio receiver. It looks for the six-word sync preamble that opens every compressed-audio burst. When it finds one, it raises a non-PCM flag and latches the two words that follow the preamble. The first of these is the burst-info word, which carries the data type, an error marker and the stream number. The second is the length-code word, which gives the burst length in bits.

The flag is held by a frame counter. Every new preamble restarts the count. If a full hold window of frames passes with no new preamble, the flag drops. Loss of receiver lock drops the flag at once.

A second flag, fed in from a separate detector for CD-carried compressed streams, is ORed with the non-PCM flag to form a combined auto-detect output. Software or a mute controller uses this output to tell that the audio path is not carrying linear PCM.

Top module: `burst_preamble_detector`

## Requirements
- R1: After a synchronous active-low reset, the non-PCM flag is 0, both captured words read 0x0000, and the auto-detect output equals the CD-stream input.
- R2: Six accepted words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F, each taken on a cycle with the word strobe high, set the non-PCM flag. The flag reads 1 in the cycle after the strobe of 0x4E1F. Cycles without the strobe neither advance nor break the match.
- R3: Any other accepted word breaks the sequence, and no flag is raised for a broken sequence. An accepted 0x0000 that breaks the sequence counts as a fresh first word. A run of four or more zeros followed by 0xF872 and 0x4E1F is a valid preamble.
- R4: The first accepted word after 0x4E1F is captured as the burst-info word. The next accepted word is captured as the length-code word. The burst-info fields are brought out as follows: data type is bits 4:0, the error marker is bit 7, and the stream number is bits 15:13.
- R5: With a hold window of HOLD_FRAMES frames, the flag stays 1 through HOLD_FRAMES-1 frame strobes after the last preamble. It reads 0 in the cycle after the HOLD_FRAMES-th frame strobe.
- R6: A new preamble while the flag is set restarts the frame count from zero.
- R7: After the window expires, further frame strobes leave the flag at 0. The counter holds its value and never sets the flag again without a new preamble.
- R8: When lock is low, the flag reads 0 in the next cycle and the frame count returns to zero. Words accepted while unlocked are ignored. The captured burst-info and length-code words keep their last values.
- R9: The auto-detect output is the OR of the non-PCM flag and the CD-stream detect input.
- R10: The 32-bit compressed-stream sync 0x7FFE 0x8001, sent as two 16-bit words alone or after zeros, sets neither the non-PCM flag nor the auto-detect output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| locked | input | 1 | Receiver lock status, 1 = locked |
| word_vld | input | 1 | Strobe: word_data holds a new sub-frame word |
| word_data | input | 16 | 16-bit audio word from the sub-frame |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| cd_stream_det | input | 1 | Detect flag from the CD-stream detector |
| npcm_flag | output | 1 | Non-PCM burst stream present |
| auto_flag | output | 1 | OR of npcm_flag and cd_stream_det |
| pc_word | output | 16 | Captured burst-info word |
| pd_word | output | 16 | Captured length-code word |
| pc_type | output | 5 | Data type field of pc_word |
| pc_err | output | 1 | Error marker of pc_word |
| pc_stream | output | 3 | Stream number field of pc_word |

## Verification
The bench builds the block with HOLD_FRAMES set to 16 instead of 4096. This makes the exact expiry edge, the retrigger that restarts the count, and the saturated state after timeout reachable in a few dozen frame strobes. The bench checks each of these at the exact strobe count. With the short window, the unlock case, the zero-run preamble variants and the rejection of the 32-bit sync word also fit in short directed sequences. The matching and capture logic does not depend on HOLD_FRAMES, so those results carry over to the default build.

// File: rtl/bpd_pkg.sv
// Package: shared constants and types for the burst preamble detector.
// Assumes a six-word sync preamble of 16-bit words, with four leading zero words.
package bpd_pkg;
    localparam int WORD_W    = 16;
    localparam int SYNC_LEN  = 6;
    localparam int ZERO_RUN  = 4;
    localparam logic [WORD_W-1:0] SYNC_A = 16'hF872;
    localparam logic [WORD_W-1:0] SYNC_B = 16'h4E1F;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PC   = 2'd1,
        CAP_PD   = 2'd2
    } cap_phase_t;

    // Expected word at a given position of the preamble.
    function automatic logic [WORD_W-1:0] sync_word(input logic [2:0] pos);
        if (pos < 3'(ZERO_RUN))          return '0;
        else if (pos == 3'(ZERO_RUN))    return SYNC_A;
        else                             return SYNC_B;
    endfunction
endpackage

// File: rtl/sync_word_matcher.sv
// Module: tracks progress through the six-word sync preamble on accepted words.
// Assumes words arrive only on word_vld; idle cycles keep the position.
// A breaking zero restarts at position 1, except after the zero run, where
// the last four zeros still form a valid prefix and the position stays.
module sync_word_matcher
    import bpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    output logic              sync_hit
);
    localparam logic [2:0] LAST_POS = 3'(SYNC_LEN - 1);
    localparam logic [2:0] RUN_POS  = 3'(ZERO_RUN);

    logic [2:0] pos_q;
    logic [2:0] pos_d;
    logic       is_zero;

    assign is_zero = (word_data == '0);

    // Purpose: flag the accepted word that completes the preamble.
    always_comb begin
        sync_hit = locked && word_vld && (pos_q == LAST_POS) && (word_data == SYNC_B);
    end

    // Purpose: compute the next match position, with zero-run aware fallback.
    always_comb begin
        pos_d = pos_q;
        if (word_vld) begin
            if (word_data == sync_word(pos_q)) begin
                pos_d = (pos_q == LAST_POS) ? 3'd0 : pos_q + 3'd1;
            end else if (is_zero) begin
                pos_d = (pos_q == RUN_POS) ? RUN_POS : 3'd1;
            end else begin
                pos_d = 3'd0;
            end
        end
    end

    // Purpose: hold the match position; cleared by reset or loss of lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) pos_q <= 3'd0;
        else                   pos_q <= pos_d;
    end

    // R3: the position never leaves the preamble length.
    a_r3_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

    // R8: while unlocked the position returns to the start.
    a_r8_pos_clear_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> pos_q == 3'd0);
endmodule

// File: rtl/preamble_capture.sv
// Module: latches the burst-info and length-code words that follow a preamble.
// Assumes sync_hit marks the accepted 0x4E1F word; the next two accepted
// words are stored. Stored words survive loss of lock.
module preamble_capture
    import bpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              sync_hit,
    output logic [WORD_W-1:0] pc_word,
    output logic [WORD_W-1:0] pd_word
);
    cap_phase_t phase_q;

    // Purpose: step through the two capture slots after each preamble.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            phase_q <= CAP_IDLE;
        end else if (sync_hit) begin
            phase_q <= CAP_PC;
        end else if (word_vld) begin
            case (phase_q)
                CAP_PC:  phase_q <= CAP_PD;
                default: phase_q <= CAP_IDLE;
            endcase
        end
    end

    // Purpose: store the burst-info and length-code words in their slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_word <= '0;
            pd_word <= '0;
        end else if (locked && word_vld && !sync_hit) begin
            if (phase_q == CAP_PC) pc_word <= word_data;
            if (phase_q == CAP_PD) pd_word <= word_data;
        end
    end

    // R4: captured words move only on an accepted word.
    a_r4_stable_without_word: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(pc_word) && $stable(pd_word));

    // R8: captured words are retained while unlocked.
    a_r8_keep_when_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> $stable(pc_word) && $stable(pd_word));

    // R4: the burst-info slot is armed right after a preamble.
    a_r4_arm_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> phase_q == CAP_PC);
endmodule

// File: rtl/frame_hold_timer.sv
// Module: keeps the non-PCM flag alive for HOLD_FRAMES frames after a preamble.
// Assumes frame_tick is a one-cycle strobe per frame. A preamble wins over a
// simultaneous frame strobe. The counter saturates once the window expires.
module frame_hold_timer #(
    parameter int HOLD_FRAMES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic locked,
    input  logic frame_tick,
    input  logic sync_hit,
    output logic active
);
    localparam int CW = (HOLD_FRAMES > 2) ? $clog2(HOLD_FRAMES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_FRAMES - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: set on a preamble, count frames, drop the flag at window end.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (sync_hit) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (active && frame_tick) begin
            if (cnt_q == LAST_CNT) active <= 1'b0;
            else                   cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R7: the count saturates and never passes the last frame.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R2: the flag rises only on a detected preamble.
    a_r2_rise_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(sync_hit));

    // R5: the final frame strobe of the window drops the flag.
    a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
        locked && active && frame_tick && !sync_hit && cnt_q == LAST_CNT |=> !active);

    // R8: loss of lock clears flag and count at once.
    a_r8_unlock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !active && cnt_q == '0);
endmodule

// File: rtl/burst_preamble_detector.sv
// Module: top of the compressed-audio burst sync detector.
// Ties the preamble matcher, the capture of the two following words and the
// frame hold timer together, and forms the combined auto-detect output.
// Assumes all inputs are synchronous to clk.
module burst_preamble_detector
    import bpd_pkg::*;
#(
    parameter int HOLD_FRAMES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        locked,
    input  logic        word_vld,
    input  logic [15:0] word_data,
    input  logic        frame_tick,
    input  logic        cd_stream_det,
    output logic        npcm_flag,
    output logic        auto_flag,
    output logic [15:0] pc_word,
    output logic [15:0] pd_word,
    output logic [4:0]  pc_type,
    output logic        pc_err,
    output logic [2:0]  pc_stream
);
    logic sync_hit;

    sync_word_matcher u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .word_vld  (word_vld),
        .word_data (word_data),
        .sync_hit  (sync_hit)
    );

    preamble_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .word_vld  (word_vld),
        .word_data (word_data),
        .sync_hit  (sync_hit),
        .pc_word   (pc_word),
        .pd_word   (pd_word)
    );

    frame_hold_timer #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .locked     (locked),
        .frame_tick (frame_tick),
        .sync_hit   (sync_hit),
        .active     (npcm_flag)
    );

    // Purpose: combined detect and burst-info field split.
    always_comb begin
        auto_flag = npcm_flag | cd_stream_det;
        pc_type   = pc_word[4:0];
        pc_err    = pc_word[7];
        pc_stream = pc_word[15:13];
    end

    // R9: with the CD-stream input low, auto-detect follows the non-PCM flag.
    a_r9_auto_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !cd_stream_det |-> auto_flag == npcm_flag);
endmodule

// File: tb/sim_burst_preamble_detector.sv
`timescale 1ns/1ps
module sim_burst_preamble_detector;
    localparam int HOLD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        locked = 1'b1;
    logic        word_vld = 1'b0;
    logic [15:0] word_data = '0;
    logic        frame_tick = 1'b0;
    logic        cd_stream_det = 1'b0;
    logic        npcm_flag, auto_flag, pc_err;
    logic [15:0] pc_word, pd_word;
    logic [4:0]  pc_type;
    logic [2:0]  pc_stream;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    burst_preamble_detector #(.HOLD_FRAMES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .locked(locked), .word_vld(word_vld),
        .word_data(word_data), .frame_tick(frame_tick), .cd_stream_det(cd_stream_det),
        .npcm_flag(npcm_flag), .auto_flag(auto_flag), .pc_word(pc_word),
        .pd_word(pd_word), .pc_type(pc_type), .pc_err(pc_err), .pc_stream(pc_stream)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; locked = 1'b1; word_vld = 1'b0; frame_tick = 1'b0; cd_stream_det = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [15:0] w, input int gap);
        @(negedge clk);
        word_vld = 1'b1; word_data = w;
        @(negedge clk);
        word_vld = 1'b0; word_data = 16'hDEAD;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic send_sync();
        send_word(16'h0000, 0); send_word(16'h0000, 0); send_word(16'h0000, 0);
        send_word(16'h0000, 0); send_word(16'hF872, 0); send_word(16'h4E1F, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_tick = 1'b1;
            @(negedge clk); frame_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flag", 16'(npcm_flag), 16'h0);
        chk("R1 pc", pc_word, 16'h0000);
        chk("R1 pd", pd_word, 16'h0000);
        chk("R1 auto", 16'(auto_flag), 16'h0);
    endtask

    task automatic t_basic();
        do_reset();
        send_word(16'h0000, 2); send_word(16'h0000, 1); send_word(16'h0000, 3);
        send_word(16'h0000, 0); send_word(16'hF872, 2);
        chk("R2 not before last word", 16'(npcm_flag), 16'h0);
        send_word(16'h4E1F, 0);
        chk("R2 flag after sync", 16'(npcm_flag), 16'h1);
        chk("R4 pc not yet", pc_word, 16'h0000);
        send_word(16'h2081, 1);
        chk("R4 pc captured", pc_word, 16'h2081);
        chk("R4 type", 16'(pc_type), 16'h0001);
        chk("R4 err", 16'(pc_err), 16'h1);
        chk("R4 stream", 16'(pc_stream), 16'h0001);
        send_word(16'h1800, 0);
        chk("R4 pd captured", pd_word, 16'h1800);
        send_word(16'h5555, 0);
        chk("R4 pd not overwritten", pd_word, 16'h1800);
    endtask

    task automatic t_broken();
        do_reset();
        send_word(16'h0000, 0); send_word(16'h0000, 0); send_word(16'h0000, 0);
        send_word(16'h0005, 0); send_word(16'h0000, 0); send_word(16'h0000, 0);
        send_word(16'hF872, 0); send_word(16'h4E1F, 0);
        chk("R3 broken no flag", 16'(npcm_flag), 16'h0);
        for (int i = 0; i < 6; i++) send_word(16'h0000, 0);
        send_word(16'hF872, 0); send_word(16'h4E1F, 0);
        chk("R3 long zero run detects", 16'(npcm_flag), 16'h1);
        do_reset();
        send_sync_partial();
        chk("R3 restart after zero at last slot", 16'(npcm_flag), 16'h1);
    endtask

    task automatic send_sync_partial();
        for (int i = 0; i < 4; i++) send_word(16'h0000, 0);
        send_word(16'hF872, 0);
        send_word(16'h0000, 0);
        chk("R3 zero breaks tail", 16'(npcm_flag), 16'h0);
        for (int i = 0; i < 3; i++) send_word(16'h0000, 0);
        send_word(16'hF872, 0); send_word(16'h4E1F, 0);
    endtask

    task automatic t_hold();
        do_reset();
        send_sync();
        ticks(HOLD - 1);
        chk("R5 held through window", 16'(npcm_flag), 16'h1);
        ticks(1);
        chk("R5 drops at window end", 16'(npcm_flag), 16'h0);
        ticks(3 * HOLD);
        chk("R7 stays low after timeout", 16'(npcm_flag), 16'h0);
        chk("R7 auto low after timeout", 16'(auto_flag), 16'h0);
    endtask

    task automatic t_retrig();
        do_reset();
        send_sync();
        ticks(HOLD - 4);
        send_sync();
        ticks(HOLD - 1);
        chk("R6 restart extends window", 16'(npcm_flag), 16'h1);
        ticks(1);
        chk("R6 drops after restarted window", 16'(npcm_flag), 16'h0);
    endtask

    task automatic t_unlock();
        do_reset();
        send_sync();
        send_word(16'h0015, 0); send_word(16'h0100, 0);
        ticks(5);
        @(negedge clk); locked = 1'b0;
        @(negedge clk);
        chk("R8 flag clears on unlock", 16'(npcm_flag), 16'h0);
        chk("R8 pc kept", pc_word, 16'h0015);
        send_sync();
        send_word(16'h7777, 0); send_word(16'h8888, 0);
        chk("R8 words ignored unlocked", 16'(npcm_flag), 16'h0);
        chk("R8 pd kept", pd_word, 16'h0100);
        @(negedge clk); locked = 1'b1;
        send_sync();
        ticks(HOLD - 1);
        chk("R8 count restarts after relock", 16'(npcm_flag), 16'h1);
    endtask

    task automatic t_auto();
        do_reset();
        @(negedge clk); cd_stream_det = 1'b1;
        #1;
        chk("R9 auto from cd input", 16'(auto_flag), 16'h1);
        chk("R9 npcm unaffected", 16'(npcm_flag), 16'h0);
        @(negedge clk); cd_stream_det = 1'b0;
        send_sync();
        chk("R9 auto from npcm", 16'(auto_flag), 16'h1);
    endtask

    task automatic t_dts();
        do_reset();
        send_word(16'h7FFE, 0); send_word(16'h8001, 0);
        for (int i = 0; i < 4; i++) send_word(16'h0000, 0);
        send_word(16'h7FFE, 0); send_word(16'h8001, 0);
        chk("R10 dts sync no npcm", 16'(npcm_flag), 16'h0);
        chk("R10 dts sync no auto", 16'(auto_flag), 16'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_broken();
        t_hold();
        t_retrig();
        t_unlock();
        t_auto();
        t_dts();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule